// File: doc/BRIEF.md
# External Data Memory Stretch Controller

This block times data-memory transfers on the external bus of an 8-bit microcontroller-style system. A requester presents an address, a read/write flag, write data and a flag that marks the target as internal SRAM. The block then holds the address, lowers the read or write strobe for a programmed width, drives the data bus during writes, captures the read data, and signals the end of the transfer with a one-clock done pulse.

A 3-bit stretch setting sets both the total transfer length and the strobe width, so slow memories and peripherals can be served without a slower system clock. One machine cycle is four clocks. From a stretch value of 4 upward, an extra machine cycle of address setup comes before the strobe and extra hold and recovery time comes after it. This is why the transfer length jumps from 5 to 9 machine cycles. Internal SRAM transfers ignore the stretch setting and always run at the fastest timing. They drive a separate internal strobe instead of the external ones.

The stretch setting is written through a small configuration port and reads 1 after reset. Each transfer takes a copy of the setting when it is accepted. While a transfer is in progress, busy is high and new requests are not accepted.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: During and right after reset, xrd_n and xwr_n are high, xdata_oe is low, int_stb is low, busy is low and done is low.
- R2: After reset the stretch setting is 1, so an external transfer lasts 12 clocks and its strobe is low for 4 clocks.
- R3: An external transfer lasts 8, 12, 16, 20, 36, 40, 44 or 48 clocks for stretch values 0 to 7. This is 2, 3, 4, 5, 9, 10, 11 or 12 machine cycles of 4 clocks. The count starts with the clock after the accepting edge and ends with the clock in which done is high.
- R4: The external strobe stays low for 2, 4, 8, 12, 16, 20, 24 or 28 consecutive clocks for stretch values 0 to 7.
- R5: The strobe goes low 4 clocks after the accepting edge for stretch values 0 to 3, and 8 clocks after it for stretch values 4 to 7. Counted from zero, these are clock indices 4 and 8.
- R6: A transfer with req_int high lasts 8 clocks whatever the stretch setting. It never lowers xrd_n or xwr_n and never raises xdata_oe. It raises int_stb for 2 clocks starting at index 4. A read of this kind returns int_rdata on rdata.
- R7: An external read captures xdata_in at the clock edge on which xrd_n returns high. rdata holds that value from then until the next read finishes, so later changes on xdata_in have no effect on it.
- R8: During an external write, xdata_oe rises one clock before xwr_n falls and falls one clock after xwr_n rises. It is therefore high for the strobe width plus 2 clocks. xdata_out equals the request's write data whenever xdata_oe is high.
- R9: A read (req_we = 0) lowers only xrd_n and a write (req_we = 1) lowers only xwr_n. The two are never low together.
- R10: busy is high from the clock after the accepting edge through the final clock of the transfer. done is high for exactly that final clock.
- R11: A request raised while busy is high is ignored: xaddr keeps the accepted address and no new transfer starts after done.
- R12: The stretch setting is copied when a request is accepted. A configuration write during a transfer changes only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Writes cfg_stretch into the stretch setting |
| cfg_stretch | input | 3 | New stretch value |
| req | input | 1 | Transfer request, accepted on a clock edge where busy is low |
| req_addr | input | 16 | Transfer address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_int | input | 1 | Target is internal SRAM |
| int_rdata | input | 8 | Read data from internal SRAM |
| xdata_in | input | 8 | Read data from the external data bus |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | High in the final clock of a transfer |
| rdata | output | 8 | Last captured read data |
| xaddr | output | 16 | Address of the current or last transfer |
| xrd_n | output | 1 | External read strobe, active low |
| xwr_n | output | 1 | External write strobe, active low |
| xdata_oe | output | 1 | Enable for driving the external data bus |
| xdata_out | output | 8 | Write data for the external bus |
| int_stb | output | 1 | Access strobe for internal SRAM |

## Verification
The bench sweeps all eight stretch values and measures the transfer length, the strobe width and where the strobe starts. A table off by one machine cycle, a missed jump between values 3 and 4, or a 0.5-cycle strobe rounded up to a full cycle would each show up as a length or position mismatch. It changes xdata_in right after the read strobe rises, so a design that captured a clock late would return the wrong value. It also measures the write-enable window on both sides of the strobe. Two further tests target the snapshot and busy rules: rewriting the stretch setting in the middle of a transfer, and a request during a transfer. A design that tracked the live setting would stretch or cut the current transfer, and one that queued the extra request would start a second transfer.

// File: rtl/xms_pkg.sv
package xms_pkg;

  localparam int unsigned STRETCH_W = 3;

  // Transfer length in machine cycles: stretched settings add setup, hold and recovery
  function automatic int unsigned total_mc(input logic [STRETCH_W-1:0] s);
    return (s < 3'd4) ? (32'(s) + 32'd2) : (32'(s) + 32'd5);
  endfunction

  // Strobe width in clocks; value 0 gives half a machine cycle
  function automatic int unsigned strobe_clk(input logic [STRETCH_W-1:0] s, input int unsigned cpm);
    return (s == '0) ? (cpm / 2) : (32'(s) * cpm);
  endfunction

  // Address setup before strobe, in clocks
  function automatic int unsigned lead_clk(input logic [STRETCH_W-1:0] s, input int unsigned cpm);
    return (s < 3'd4) ? cpm : (2 * cpm);
  endfunction

endpackage

// File: rtl/xms_rst_sync.sv
module xms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/xms_timing.sv
module xms_timing #(
  parameter int CPM   = 4,
  parameter int CNT_W = 6
) (
  input  logic [xms_pkg::STRETCH_W-1:0] stretch,
  input  logic                          is_int,
  output logic [CNT_W-1:0]              lead_c,
  output logic [CNT_W-1:0]              strb_c,
  output logic [CNT_W-1:0]              total_c
);
  logic [xms_pkg::STRETCH_W-1:0] eff_s;

  always_comb begin
    // internal SRAM always takes the fastest timing
    eff_s   = is_int ? '0 : stretch;
    lead_c  = CNT_W'(xms_pkg::lead_clk(eff_s, CPM));
    strb_c  = CNT_W'(xms_pkg::strobe_clk(eff_s, CPM));
    total_c = CNT_W'(xms_pkg::total_mc(eff_s) * CPM);
  end
endmodule

// File: rtl/xms_seq.sv
module xms_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_c,
  output logic             active,
  output logic             last,
  output logic [CNT_W-1:0] cnt
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = act_q && (cnt_q == total_c - CNT_W'(1));

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/xms_strobe.sv
module xms_strobe #(
  parameter int CNT_W = 6
) (
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] lead_c,
  input  logic [CNT_W-1:0] strb_c,
  input  logic             we,
  input  logic             is_int,
  output logic             rd_n,
  output logic             wr_n,
  output logic             oe,
  output logic             int_stb,
  output logic             cap
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] c_e, l_e, end_e;
  logic          win;

  always_comb begin
    c_e   = EW'(cnt);
    l_e   = EW'(lead_c);
    end_e = EW'(lead_c) + EW'(strb_c);
    win   = active && (c_e >= l_e) && (c_e < end_e);
    rd_n    = !(win && !we && !is_int);
    wr_n    = !(win &&  we && !is_int);
    int_stb = win && is_int;
    // bus driven one clock either side of the write strobe
    oe      = active && we && !is_int && (c_e + EW'(1) >= l_e) && (c_e <= end_e);
    cap     = win && !we && (c_e == end_e - EW'(1));
  end
endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CPM           = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int RESET_STRETCH = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [xms_pkg::STRETCH_W-1:0] cfg_stretch,
  input  logic                          req,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_we,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic                          req_int,
  input  logic [DATA_W-1:0]             int_rdata,
  input  logic [DATA_W-1:0]             xdata_in,
  output logic                          busy,
  output logic                          done,
  output logic [DATA_W-1:0]             rdata,
  output logic [ADDR_W-1:0]             xaddr,
  output logic                          xrd_n,
  output logic                          xwr_n,
  output logic                          xdata_oe,
  output logic [DATA_W-1:0]             xdata_out,
  output logic                          int_stb
);
  localparam int SW    = xms_pkg::STRETCH_W;
  localparam int MAX_C = 12 * CPM;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic              srst_n;
  logic              active, last, start, cap;
  logic [CNT_W-1:0]  cnt, lead_c, strb_c, total_c;

  logic [SW-1:0]     cfg_q, cfg_d;
  logic [SW-1:0]     snap_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic              we_q, int_q;

  xms_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  assign start = req && !active;

  // next-state
  always_comb begin
    cfg_d   = cfg_we ? cfg_stretch : cfg_q;
    rdata_d = int_q ? int_rdata : xdata_in;
  end

  // configuration register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cfg_q <= SW'(RESET_STRETCH);
    else if (cfg_we) cfg_q <= cfg_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      snap_q  <= SW'(RESET_STRETCH);
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      int_q   <= 1'b0;
    end else if (start) begin
      snap_q  <= cfg_q;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
      int_q   <= req_int;
    end
  end

  // read data capture, enabled on the strobe's last clock
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  rdata_q <= '0;
    else if (cap) rdata_q <= rdata_d;
  end

  xms_timing #(.CPM(CPM), .CNT_W(CNT_W)) u_tim (
    .stretch(snap_q), .is_int(int_q),
    .lead_c(lead_c), .strb_c(strb_c), .total_c(total_c)
  );

  xms_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .srst_n(srst_n), .start(start), .total_c(total_c),
    .active(active), .last(last), .cnt(cnt)
  );

  xms_strobe #(.CNT_W(CNT_W)) u_stb (
    .active(active), .cnt(cnt), .lead_c(lead_c), .strb_c(strb_c),
    .we(we_q), .is_int(int_q),
    .rd_n(xrd_n), .wr_n(xwr_n), .oe(xdata_oe), .int_stb(int_stb), .cap(cap)
  );

  assign busy      = active;
  assign done      = last;
  assign rdata     = rdata_q;
  assign xaddr     = addr_q;
  assign xdata_out = wdata_q;
endmodule

// File: rtl/xmem_stretch_ctrl_chk.sv
module xmem_stretch_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] xaddr,
  input logic              xrd_n,
  input logic              xwr_n,
  input logic              xdata_oe,
  input logic              int_stb
);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xrd_n && !xwr_n));

  p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xrd_n |-> !xdata_oe);

  p_oe_leads_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xwr_n) |-> $past(xdata_oe));

  p_oe_trails_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xwr_n) |-> xdata_oe);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n || !xwr_n || int_stb) |-> busy);

  p_addr_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(xaddr));

  p_int_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_stb |-> (xrd_n && xwr_n && !xdata_oe));
endmodule

bind xmem_stretch_ctrl xmem_stretch_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .xaddr(xaddr),
  .xrd_n(xrd_n), .xwr_n(xwr_n), .xdata_oe(xdata_oe), .int_stb(int_stb)
);

// File: tb/xmem_stretch_ctrl_tb_top.sv
module xmem_stretch_ctrl_tb_top;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_stretch;
  logic        req, req_we, req_int;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, int_rdata, xdata_in;
  logic        busy, done, xrd_n, xwr_n, xdata_oe, int_stb;
  logic [7:0]  rdata, xdata_out;
  logic [15:0] xaddr;

  int n_chk, n_fail;
  // measurements of one transfer
  int m_total, m_rd, m_wr, m_int, m_first, m_oe, m_oe_first, m_oe_bad;
  int m_done, m_addr_bad, m_busy_bad;

  xmem_stretch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
    .req(req), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_int(req_int), .int_rdata(int_rdata), .xdata_in(xdata_in),
    .busy(busy), .done(done), .rdata(rdata), .xaddr(xaddr),
    .xrd_n(xrd_n), .xwr_n(xwr_n), .xdata_oe(xdata_oe), .xdata_out(xdata_out),
    .int_stb(int_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_total(input int s);
    return 4 * ((s < 4) ? s + 2 : s + 5);
  endfunction
  function automatic int exp_strb(input int s);
    return (s == 0) ? 2 : 4 * s;
  endfunction
  function automatic int exp_lead(input int s);
    return (s >= 4) ? 8 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_stretch(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stretch = 3'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one transfer; mid_cfg rewrites stretch to 0 at index 2, mid_req raises a stray request at index 3
  task automatic do_xfer(input logic [15:0] a, input bit we, input bit isint,
                         input logic [7:0] wd, input logic [7:0] rv,
                         input bit mid_cfg, input bit mid_req);
    bit seen_stb;
    m_total = -1; m_rd = 0; m_wr = 0; m_int = 0; m_first = -1;
    m_oe = 0; m_oe_first = -1; m_oe_bad = 0; m_done = 0; m_addr_bad = 0; m_busy_bad = 0;
    seen_stb = 1'b0;
    @(negedge clk);
    xdata_in = rv; int_rdata = rv;
    req = 1'b1; req_addr = a; req_we = we; req_int = isint; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (!xrd_n) m_rd++;
      if (!xwr_n) m_wr++;
      if (int_stb) m_int++;
      if ((!xrd_n || !xwr_n || int_stb) && m_first < 0) m_first = k;
      if (!xrd_n || !xwr_n || int_stb) seen_stb = 1'b1;
      else if (seen_stb) begin xdata_in = ~rv; int_rdata = ~rv; end
      if (xdata_oe) begin
        m_oe++;
        if (m_oe_first < 0) m_oe_first = k;
        if (xdata_out !== wd) m_oe_bad++;
      end
      if (!busy) m_busy_bad++;
      if (xaddr !== a) m_addr_bad++;
      if (mid_cfg && k == 2) begin cfg_we = 1'b1; cfg_stretch = 3'd0; end
      if (mid_cfg && k == 3) cfg_we = 1'b0;
      if (mid_req && k == 3) begin req = 1'b1; req_addr = ~a; end
      if (mid_req && k == 4) begin req = 1'b0; req_addr = a; end
      if (done) begin m_done++; m_total = k + 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    if (done) m_done++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(xrd_n && xwr_n, "R1 strobes idle", {xrd_n, xwr_n}, 3);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    chk(!xdata_oe && !int_stb, "R1 oe/int idle", {xdata_oe, int_stb}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(xrd_n && xwr_n && !busy && !done && !xdata_oe, "R1 after release", busy, 0);
  endtask

  task automatic t_default;
    do_xfer(16'h1234, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b0);
    chk(m_total == 12, "R2 default length", m_total, 12);
    chk(m_rd == 4, "R2 default strobe", m_rd, 4);
    chk(rdata == 8'h5A, "R7 default read data", rdata, 8'h5A);
  endtask

  task automatic t_sweep_read;
    for (int s = 0; s < 8; s++) begin
      set_stretch(s);
      do_xfer(16'h0100 + 16'(s), 1'b0, 1'b0, 8'h00, 8'(8'h30 + s), 1'b0, 1'b0);
      chk(m_total == exp_total(s), "R3 read length", m_total, exp_total(s));
      chk(m_rd == exp_strb(s), "R4 read strobe width", m_rd, exp_strb(s));
      chk(m_first == exp_lead(s), "R5 strobe start", m_first, exp_lead(s));
      chk(m_wr == 0 && m_oe == 0, "R9 no write strobe on read", m_wr, 0);
      chk(rdata == 8'(8'h30 + s), "R7 captured data", rdata, 8'h30 + s);
      chk(m_done == 1 && m_busy_bad == 0, "R10 done/busy", m_done, 1);
    end
  endtask

  task automatic t_sweep_write;
    for (int i = 0; i < 4; i++) begin
      int s;
      s = (i == 0) ? 0 : (i == 1) ? 3 : (i == 2) ? 4 : 7;
      set_stretch(s);
      do_xfer(16'hA000 + 16'(s), 1'b1, 1'b0, 8'(8'hC0 + s), 8'h00, 1'b0, 1'b0);
      chk(m_total == exp_total(s), "R3 write length", m_total, exp_total(s));
      chk(m_wr == exp_strb(s), "R4 write strobe width", m_wr, exp_strb(s));
      chk(m_rd == 0, "R9 no read strobe on write", m_rd, 0);
      chk(m_oe == exp_strb(s) + 2, "R8 oe window length", m_oe, exp_strb(s) + 2);
      chk(m_oe_first == exp_lead(s) - 1, "R8 oe start", m_oe_first, exp_lead(s) - 1);
      chk(m_oe_bad == 0, "R8 bus data", m_oe_bad, 0);
    end
  endtask

  task automatic t_internal;
    set_stretch(7);
    do_xfer(16'h0040, 1'b0, 1'b1, 8'h00, 8'h9C, 1'b0, 1'b0);
    chk(m_total == 8, "R6 internal read length", m_total, 8);
    chk(m_rd == 0 && m_wr == 0 && m_oe == 0, "R6 no external activity", m_rd + m_wr + m_oe, 0);
    chk(m_int == 2 && m_first == 4, "R6 internal strobe", m_int, 2);
    chk(rdata == 8'h9C, "R6 internal read data", rdata, 8'h9C);
    do_xfer(16'h0041, 1'b1, 1'b1, 8'h77, 8'h00, 1'b0, 1'b0);
    chk(m_total == 8 && m_wr == 0 && m_oe == 0, "R6 internal write", m_total, 8);
    chk(rdata == 8'h9C, "R7 rdata kept over write", rdata, 8'h9C);
  endtask

  task automatic t_snapshot;
    set_stretch(7);
    do_xfer(16'h2222, 1'b0, 1'b0, 8'h00, 8'h11, 1'b1, 1'b0);
    chk(m_total == 48, "R12 current transfer keeps old setting", m_total, 48);
    chk(m_rd == 28, "R12 strobe kept", m_rd, 28);
    do_xfer(16'h2223, 1'b0, 1'b0, 8'h00, 8'h12, 1'b0, 1'b0);
    chk(m_total == 8, "R12 next transfer uses new setting", m_total, 8);
  endtask

  task automatic t_busy;
    set_stretch(2);
    do_xfer(16'h3C3C, 1'b0, 1'b0, 8'h00, 8'h44, 1'b0, 1'b1);
    chk(m_addr_bad == 0, "R11 address held", m_addr_bad, 0);
    chk(m_total == 16, "R11 length unchanged", m_total, 16);
    for (int j = 0; j < 4; j++) begin
      chk(!busy && xrd_n, "R11 no second transfer", busy, 0);
      @(negedge clk);
    end
    chk(xaddr == 16'h3C3C, "R11 xaddr after", xaddr, 16'h3C3C);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_stretch = '0; req = 1'b0; req_we = 1'b0;
    req_int = 1'b0; req_addr = '0; req_wdata = '0; int_rdata = '0; xdata_in = '0;
    t_reset();
    t_default();
    t_sweep_read();
    t_sweep_write();
    t_internal();
    t_snapshot();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule